// File: doc/BRIEF.md
# Low-Power Mode Controller

This block is the power-saving sequencer of a small 8-bit microcontroller. It runs on the oscillator clock. Software selects a low-power mode by writing a control register through a plain address/data write port. The block then gates three clock enables: one for the CPU, one for the peripherals and one that keeps the oscillator running. It also qualifies the external reset pin over machine cycles and drives an internal reset and a RAM write-inhibit.

The sequencer has four states. ST_RUN is normal operation. ST_IDLE stops only the CPU clock. ST_PDOWN stops every clock, including the oscillator. ST_RSTWIN is a short window that opens when the reset pin goes high during idle: the CPU clock runs again, but RAM writes are blocked until the reset qualifies.

The transitions are:
- RUN→IDLE: a control write with only the idle bit set.
- RUN→PDOWN: a control write with the power-down bit set.
- IDLE→RUN: an enabled interrupt.
- IDLE→RSTWIN: the reset pin is high.
- RSTWIN→IDLE: the reset pin drops before it qualifies.
- Any state→RUN: a qualified internal reset.

The mode output is a 2-bit code: run 00, idle 01, power-down 10. The reset window reports 01, because idle has not yet been left.

Top module: `lp_mode_ctrl`

## Requirements
- R1: A machine cycle is OSC_PER_MC (12) oscillator clocks. int_rst goes high after the rising edge at which the reset pin has been sampled high on RST_MCYC*OSC_PER_MC (24) consecutive edges. It stays high while the pin stays high. A shorter pulse never raises it.
- R2: In ST_RUN, a write to CTRL_ADDR (default 8'h40) sets the mode from data bit 0 (idle) and data bit 1 (power-down). The new mode is visible after that edge. A write with neither bit set leaves the mode at run. A write to any other address has no effect. Writes are ignored outside ST_RUN.
- R3: In ST_IDLE: mode is 01, cpu_clk_en is 0, per_clk_en is 1 and osc_en is 1.
- R4: In ST_PDOWN: mode is 10 and cpu_clk_en and per_clk_en are 0. osc_en is 0 while the reset pin is low and follows the pin high, so the oscillator can restart.
- R5: A write with both bits set enters power-down, not idle.
- R6: An interrupt request in ST_IDLE returns the block to run at the next edge. The request has no effect in ST_RUN or ST_PDOWN.
- R7: ST_PDOWN is left only through a qualified reset. The mode reads run one edge after int_rst rises.
- R8: A high reset pin in ST_IDLE enters ST_RSTWIN at the next edge. In that state cpu_clk_en=1, per_clk_en=1 and ram_wr_block=1. The block goes to run one edge after int_rst rises. If the pin drops first, it returns to idle.
- R9: ram_wr_block is high whenever int_rst is high. A qualified reset forces mode 00 from any state.
- R10: After power-on reset (por_n low): mode 00, all three clock enables 1, int_rst 0 and ram_wr_block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, sampled on clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| irq_pend | input | 1 | Any enabled interrupt request |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_wr_block | output | 1 | Internal RAM write inhibit |
| mode | output | 2 | Mode code: 00 run, 01 idle, 10 power-down |

## Verification
The checker watches every cycle for the following:
- clock enables that do not match the reported mode;
- a departure from power-down without a prior internal reset;
- a quiet idle that changes mode;
- a two-bit write that fails to enter power-down;
- an internal reset without the pin having been high.

The exact qualification count of 24 edges and the rejection of a 23-edge pulse can only be shown by the bench's scenarios, since the length is held in a counter rather than a property. The same holds for the length of the reset window out of idle and the return to idle after an aborted reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_PDOWN = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_RSTWIN
    } state_e;
endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
    parameter int OSC_PER_MC = 12,
    parameter int RST_MCYC   = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    output logic rst_ok
);
    localparam int QUAL_CLKS = OSC_PER_MC * RST_MCYC;
    localparam int CW        = $clog2(QUAL_CLKS + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            hi_cnt <= '0;
        else if (!rst_pin)
            hi_cnt <= '0;
        else if (hi_cnt != CW'(QUAL_CLKS))
            hi_cnt <= hi_cnt + 1'b1;
    end

    assign rst_ok = (hi_cnt == CW'(QUAL_CLKS));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic  clk,
    input  logic  por_n,
    input  logic  int_rst,
    input  logic  rst_pin,
    input  logic  irq_pend,
    input  logic  wr_hit,
    input  logic  wr_idle,
    input  logic  wr_pd,
    output logic  cpu_clk_en,
    output logic  per_clk_en,
    output logic  osc_en,
    output logic  ram_wr_block,
    output mode_e mode
);
    state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (int_rst) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (wr_hit) begin
                        if (wr_pd)        state_nx = ST_PDOWN;
                        else if (wr_idle) state_nx = ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (rst_pin)       state_nx = ST_RSTWIN;
                    else if (irq_pend) state_nx = ST_RUN;
                end
                ST_PDOWN:  state_nx = ST_PDOWN;
                ST_RSTWIN: begin
                    if (!rst_pin) state_nx = ST_IDLE;
                end
                default:   state_nx = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        cpu_clk_en   = 1'b1;
        per_clk_en   = 1'b1;
        osc_en       = 1'b1;
        ram_wr_block = int_rst;
        mode         = MODE_RUN;
        unique case (state)
            ST_RUN: ;
            ST_IDLE: begin
                cpu_clk_en = 1'b0;
                mode       = MODE_IDLE;
            end
            ST_PDOWN: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = rst_pin;
                mode       = MODE_PDOWN;
            end
            ST_RSTWIN: begin
                ram_wr_block = 1'b1;
                mode         = MODE_IDLE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
    import lpm_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  CTRL_ADDR  = 8'h40,
    parameter int          IDLE_BIT   = 0,
    parameter int          PD_BIT     = 1,
    parameter int          OSC_PER_MC = 12,
    parameter int          RST_MCYC   = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_pend,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic              int_rst,
    output logic              ram_wr_block,
    output logic [1:0]        mode
);
    logic  wr_hit;
    mode_e mode_int;

    assign wr_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    lpm_rst_qual #(
        .OSC_PER_MC (OSC_PER_MC),
        .RST_MCYC   (RST_MCYC)
    ) u_qual (
        .clk     (clk),
        .por_n   (por_n),
        .rst_pin (rst_pin),
        .rst_ok  (int_rst)
    );

    lpm_fsm u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .int_rst      (int_rst),
        .rst_pin      (rst_pin),
        .irq_pend     (irq_pend),
        .wr_hit       (wr_hit),
        .wr_idle      (wr_data[IDLE_BIT]),
        .wr_pd        (wr_data[PD_BIT]),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_en       (osc_en),
        .ram_wr_block (ram_wr_block),
        .mode         (mode_int)
    );

    assign mode = mode_int;
endmodule

// File: rtl/lpm_mode_chk.sv
module lpm_mode_chk #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  CTRL_ADDR = 8'h40,
    parameter int          PD_BIT    = 1
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_pin,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_pend,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic              osc_en,
    input logic              int_rst,
    input logic              ram_wr_block,
    input logic [1:0]        mode
);
    // R4
    pdown_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'b10) |-> (!cpu_clk_en && !per_clk_en && (osc_en == rst_pin)));

    // R3
    idle_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'b01 && !ram_wr_block) |-> (!cpu_clk_en && per_clk_en && osc_en));

    // R7
    pdown_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'b10 && !int_rst) |=> (mode == 2'b10));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'b01 && !ram_wr_block && !irq_pend && !rst_pin) |=> (mode == 2'b01));

    // R5
    both_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'b00 && !int_rst && wr_en && wr_addr == ADDR_W'(CTRL_ADDR) && wr_data[PD_BIT])
        |=> (mode == 2'b10));

    // R1
    rst_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(int_rst) |-> $past(rst_pin));

    // R9
    rst_run_chk: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |=> (mode == 2'b00));
endmodule

bind lp_mode_ctrl lpm_mode_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .PD_BIT    (PD_BIT)
) u_chk (.*);

// File: tb/tb_lp_mode_ctrl.sv
module tb_lp_mode_ctrl;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] CTRL       = 8'h40;
    localparam int         QUAL       = 24;

    logic       clk = 0;
    logic       por_n = 0;
    logic       rst_pin = 0;
    logic       wr_en = 0;
    logic [7:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       irq_pend = 0;
    logic       cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_block;
    logic [1:0] mode;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_mode_ctrl dut (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq_pend(irq_pend),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .int_rst(int_rst), .ram_wr_block(ram_wr_block), .mode(mode)
    );

    // entry: [9] wr_en [8] addr ok [7] pd [6] idle [5] irq [4] exp osc [3:2] exp mode [1] exp cpu [0] exp per
    localparam int NV = 8;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_1_00_0_1_00_1_1,  // R2 write neither bit: stay run
        10'b1_0_01_0_1_00_1_1,  // R2 wrong address: no effect
        10'b1_1_01_0_1_01_0_1,  // R3 enter idle
        10'b1_1_10_0_1_01_0_1,  // R2 write ignored in idle
        10'b0_1_00_1_1_00_1_1,  // R6 interrupt leaves idle
        10'b0_1_00_1_1_00_1_1,  // R6 interrupt no effect in run
        10'b1_1_11_0_0_10_0_0,  // R5 both bits: power-down
        10'b0_1_00_1_0_10_0_0   // R6 interrupt ignored in power-down
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic go_idle();
        wr_en = 1; wr_addr = CTRL; wr_data = 8'h01;
        step();
        wr_en = 0; wr_data = 0;
    endtask

    initial begin
        #(CLK_PERIOD*3);
        #1;
        // R10 reset state
        chk("R10 mode", mode, 0);
        chk("R10 enables", {cpu_clk_en, per_clk_en, osc_en}, 7);
        chk("R10 int_rst/blk", {int_rst, ram_wr_block}, 0);
        por_n = 1;
        step();

        for (int v = 0; v < NV; v++) begin
            wr_en    = VEC[v][9];
            wr_addr  = VEC[v][8] ? CTRL : (CTRL ^ 8'h01);
            wr_data  = {6'b0, VEC[v][7:6]};
            irq_pend = VEC[v][5];
            step();
            chk($sformatf("R2-table vec%0d mode", v), mode, VEC[v][3:2]);
            chk($sformatf("R3 vec%0d cpu", v), cpu_clk_en, VEC[v][1]);
            chk($sformatf("R4 vec%0d per", v), per_clk_en, VEC[v][0]);
            chk($sformatf("R4 vec%0d osc", v), osc_en, VEC[v][4]);
        end
        wr_en = 0; wr_data = 0; irq_pend = 0;

        // R4 / R7: power-down exit through reset
        rst_pin = 1;
        #1;
        chk("R4 osc follows pin", osc_en, 1);
        steps(QUAL - 1);
        chk("R7 no reset at 23", int_rst, 0);
        chk("R7 still pdown", mode, 2);
        step();
        chk("R1 int_rst at 24", int_rst, 1);
        chk("R9 blk with int_rst", ram_wr_block, 1);
        step();
        chk("R7 run after reset", mode, 0);
        rst_pin = 0;
        step();
        chk("R1 int_rst drops", int_rst, 0);

        // R8: reset window out of idle
        go_idle();
        chk("R3 idle", mode, 1);
        rst_pin = 1;
        step();
        chk("R8 window mode", mode, 1);
        chk("R8 window cpu", cpu_clk_en, 1);
        chk("R8 window blk", ram_wr_block, 1);
        steps(QUAL - 1);
        chk("R8 int_rst at 24", int_rst, 1);
        step();
        chk("R8 run after reset", mode, 0);
        rst_pin = 0;
        step();

        // R8: aborted reset in idle returns to idle
        go_idle();
        rst_pin = 1;
        steps(QUAL - 1);
        chk("R1 short pulse no rst", int_rst, 0);
        chk("R8 short pulse cpu", cpu_clk_en, 1);
        rst_pin = 0;
        step();
        chk("R8 back to idle", mode, 1);
        chk("R8 back cpu off", cpu_clk_en, 0);
        chk("R8 back blk off", ram_wr_block, 0);
        irq_pend = 1;
        step();
        irq_pend = 0;
        chk("R6 irq exit", mode, 0);

        // R1: short pulse in run
        rst_pin = 1;
        steps(QUAL - 1);
        chk("R1 run 23 edges", int_rst, 0);
        step();
        chk("R1 run 24 edges", int_rst, 1);
        rst_pin = 0;
        step();
        chk("R9 run mode", mode, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule